// File: doc/BRIEF.md
# Serial Status Readout Shift Register

This block captures a fixed-layout status word when the latch strobe arrives and then sends it out one bit per serial shift, most significant bit first. The word combines live fault information with an echo of configuration data. It holds one open-load flag per output channel, a single over-temperature flag, and a copy of every channel's dot-correction setting. All remaining positions are reserved and read as zero. The serial shift clock is treated as a single-cycle enable, `shiftEn`, that is synchronous to `clk`.

The status word is shifted out while the next grayscale word is being shifted into the neighbouring input register. After a load, the serial output already shows the word's top bit. The first shift moves the next bit, top minus one, onto the output. This lets the receiver capture the top status bit before it issues any shift clock.

Each channel's open-load flag counts only while that channel's output is switched on. The flag inputs are masked with the channel-on vector before they reach the word or the error output. A combined active-low error output goes low whenever any masked open-load flag or the thermal flag is set. Analog sensing is done elsewhere, and the flags arrive here as digital inputs.

Top module: `status_shift_out`

## Requirements
- R1: While `rstN` is low, and after it rises until the first strobe, `serOut` is 0 and `errN` is 1.
- R2: In the cycle after the `clk` edge that samples `latchStb` high, the word holds the newly composed status, and `serOut` equals word bit 191, which is a reserved bit.
- R3: Layout of the loaded word, with word width 192:
  - bit c (c = 0..15) is the masked open-load flag of channel c;
  - bit 16 is `thermalFlag`;
  - bits 17..23 are 0;
  - bit 24+6c+b is bit b of channel c's dot-correction value, taken from `dcValues[6c+b]`;
  - bits 120..191 are 0.
- R4: Each `clk` edge with `shiftEn` high and `latchStb` low moves the word one place toward the top and fills a 0 at the bottom. After k such shifts, `serOut` shows word bit 191-k, and after 192 shifts it shows 0.
- R5: The open-load flag of a channel whose `chanOn` bit is 0 is stored as 0 and does not affect `errN`.
- R6: `errN` is registered. One cycle after any masked open-load flag or `thermalFlag` is high, `errN` is 0; otherwise it is 1.
- R7: When `latchStb` and `shiftEn` are both high on the same edge, the load wins and no shift happens.
- R8: On an edge with neither strobe high, the word and `serOut` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchStb | input | 1 | Load the status word (one-cycle strobe) |
| shiftEn | input | 1 | Serial shift strobe, one bit per pulse |
| chanOn | input | 16 | Per-channel output-on indication, used as the open-load mask |
| openLoadRaw | input | 16 | Raw per-channel open-load detections |
| thermalFlag | input | 1 | Over-temperature detection |
| dcValues | input | 96 | Dot-correction values, channel c in bits 6c+5..6c |
| serOut | output | 1 | Serial status output, top bit of the word |
| errN | output | 1 | Active-low combined error |

## Verification
A corrupted word bit stays hidden until enough shifts have brought it to the top. A bad bit 0 therefore shows only after 191 shifts, so the bench streams every loaded word completely and compares each bit against its model. A wrong mask or a wrong flag position shows either in the streamed low bits or on `errN` one cycle after the inputs change. A priority or hold fault shows on `serOut` at the very next edge.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } statusCtrl_t;
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import status_pkg::*;
(
  input  logic        latchStb,
  input  logic        shiftEn,
  output statusCtrl_t ctrl
);
  // Load has priority over shift (R7)
  always_comb begin
    ctrl.load  = latchStb;
    ctrl.shift = shiftEn & ~latchStb;
  end
endmodule

// File: rtl/status_datapath.sv
module status_datapath
  import status_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int DC_BITS   = 6,
  parameter int WORD_BITS = 192
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  statusCtrl_t               ctrl,
  input  logic [NUM_CH-1:0]         chanOn,
  input  logic [NUM_CH-1:0]         openLoadRaw,
  input  logic                      thermalFlag,
  input  logic [NUM_CH*DC_BITS-1:0] dcValues,
  output logic [WORD_BITS-1:0]      statusWord,
  output logic                      errN
);
  localparam int TEF_POS = NUM_CH;
  localparam int DC_LSB  = ((NUM_CH + 1 + 7) / 8) * 8;
  localparam int DC_MSB  = DC_LSB + NUM_CH * DC_BITS - 1;

  logic [NUM_CH-1:0]  maskedOl;
  wire [WORD_BITS-1:0] loadWord;
  logic               errReg;

  assign maskedOl = openLoadRaw & chanOn;

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      assign loadWord[ch] = maskedOl[ch];
      assign loadWord[DC_LSB + ch*DC_BITS +: DC_BITS] = dcValues[ch*DC_BITS +: DC_BITS];
    end
    if (DC_LSB - 1 > TEF_POS) begin : g_gapLow
      assign loadWord[DC_LSB-1:TEF_POS+1] = '0;
    end
    if (WORD_BITS - 1 > DC_MSB) begin : g_gapHigh
      assign loadWord[WORD_BITS-1:DC_MSB+1] = '0;
    end
  endgenerate
  assign loadWord[TEF_POS] = thermalFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWord <= '0;
    end else if (ctrl.load) begin
      statusWord <= loadWord;
    end else if (ctrl.shift) begin
      statusWord <= {statusWord[WORD_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errReg <= 1'b0;
    else       errReg <= (|maskedOl) | thermalFlag;
  end

  assign errN = ~errReg;
endmodule

// File: rtl/status_shift_out.sv
module status_shift_out
  import status_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int DC_BITS   = 6,
  parameter int WORD_BITS = 192
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      latchStb,
  input  logic                      shiftEn,
  input  logic [NUM_CH-1:0]         chanOn,
  input  logic [NUM_CH-1:0]         openLoadRaw,
  input  logic                      thermalFlag,
  input  logic [NUM_CH*DC_BITS-1:0] dcValues,
  output logic                      serOut,
  output logic                      errN
);
  statusCtrl_t           ctrl;
  logic [WORD_BITS-1:0]  statusWord;

  status_ctrl i_ctrl (
    .latchStb (latchStb),
    .shiftEn  (shiftEn),
    .ctrl     (ctrl)
  );

  status_datapath #(
    .NUM_CH    (NUM_CH),
    .DC_BITS   (DC_BITS),
    .WORD_BITS (WORD_BITS)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .chanOn      (chanOn),
    .openLoadRaw (openLoadRaw),
    .thermalFlag (thermalFlag),
    .dcValues    (dcValues),
    .statusWord  (statusWord),
    .errN        (errN)
  );

  assign serOut = statusWord[WORD_BITS-1];
endmodule

// File: rtl/status_shift_out_chk.sv
module status_shift_out_chk #(
  parameter int NUM_CH    = 16,
  parameter int WORD_BITS = 192
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 latchStb,
  input logic                 shiftEn,
  input logic [NUM_CH-1:0]    chanOn,
  input logic [NUM_CH-1:0]    openLoadRaw,
  input logic                 thermalFlag,
  input logic [WORD_BITS-1:0] statusWord,
  input logic                 serOut,
  input logic                 errN
);
  localparam int DC_LSB = ((NUM_CH + 1 + 7) / 8) * 8;

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> (statusWord == '0 && errN));

  a_r2_load_top: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |=> !serOut);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |=> (statusWord[WORD_BITS-1:DC_LSB+NUM_CH*6] == '0 &&
                  statusWord[DC_LSB-1:NUM_CH+1] == '0));

  a_r4_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !latchStb) |=> serOut == $past(statusWord[WORD_BITS-2]));

  a_r5_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |=> (statusWord[NUM_CH-1:0] & ~$past(chanOn)) == '0);

  a_r6_thermal_err: assert property (@(posedge clk) disable iff (!rstN)
    thermalFlag |=> !errN);

  a_r6_quiet_err: assert property (@(posedge clk) disable iff (!rstN)
    (!thermalFlag && ((openLoadRaw & chanOn) == '0)) |=> errN);

  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && shiftEn) |=> statusWord[NUM_CH] == $past(thermalFlag));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!latchStb && !shiftEn) |=> $stable(statusWord));
endmodule

bind status_shift_out status_shift_out_chk #(
  .NUM_CH    (NUM_CH),
  .WORD_BITS (WORD_BITS)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .latchStb    (latchStb),
  .shiftEn     (shiftEn),
  .chanOn      (chanOn),
  .openLoadRaw (openLoadRaw),
  .thermalFlag (thermalFlag),
  .statusWord  (statusWord),
  .serOut      (serOut),
  .errN        (errN)
);

// File: tb/test_status_shift_out.sv
`timescale 1ns/1ps
module test_status_shift_out;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        latchStb = 1'b0;
  logic        shiftEn = 1'b0;
  logic [15:0] chanOn = '0;
  logic [15:0] openLoadRaw = '0;
  logic        thermalFlag = 1'b0;
  logic [95:0] dcValues = '0;
  logic        serOut;
  logic        errN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  bit modelWord [0:191];
  bit modelErr = 1'b0;

  always #10 clk = ~clk;

  status_shift_out i_status_shift_out (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .shiftEn(shiftEn),
    .chanOn(chanOn), .openLoadRaw(openLoadRaw), .thermalFlag(thermalFlag),
    .dcValues(dcValues), .serOut(serOut), .errN(errN)
  );

  function automatic bit composeBit(int idx);
    if (idx < 16) return openLoadRaw[idx] & chanOn[idx];
    if (idx == 16) return thermalFlag;
    if (idx >= 24 && idx < 120) return dcValues[idx-24];
    return 1'b0;
  endfunction

  // Behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int i = 0; i < 192; i++) modelWord[i] = 1'b0;
      modelErr = 1'b0;
    end else begin
      bit anyFault;
      anyFault = thermalFlag;
      for (int c = 0; c < 16; c++) if (openLoadRaw[c] && chanOn[c]) anyFault = 1'b1;
      if (latchStb) begin
        for (int i = 0; i < 192; i++) modelWord[i] = composeBit(i);
      end else if (shiftEn) begin
        for (int i = 191; i > 0; i--) modelWord[i] = modelWord[i-1];
        modelWord[0] = 1'b0;
      end
      modelErr = anyFault;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (serOut !== modelWord[191]) begin
      errors++;
      $display("FAIL %s serOut actual=%b expected=%b at cycle %0d", curReq, serOut, modelWord[191], cycles);
    end
    checks++;
    if (errN !== !modelErr) begin
      errors++;
      $display("FAIL %s errN actual=%b expected=%b at cycle %0d", curReq, errN, !modelErr, cycles);
    end
  end

  always @(posedge clk) begin
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    latchStb = 1'b0; shiftEn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic latchNow();
    latchStb = 1'b1; shiftEn = 1'b0;
    @(negedge clk);
    latchStb = 1'b0;
  endtask

  task automatic shiftN(int n, bit gaps);
    for (int k = 0; k < n; k++) begin
      shiftEn = 1'b1;
      @(negedge clk);
      shiftEn = 1'b0;
      if (gaps && (k % 5 == 2)) @(negedge clk);
    end
  endtask

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R8";
    idle(3);

    // Full stream with all channels on
    for (int i = 0; i < 96; i++) dcValues[i] = ((i * 7 + i / 3) % 3) == 1;
    chanOn = 16'hFFFF; openLoadRaw = 16'hA5C3; thermalFlag = 1'b0;
    curReq = "R2"; latchNow();
    curReq = "R3"; shiftN(100, 1'b1);
    curReq = "R8"; idle(4);
    curReq = "R4"; shiftN(96, 1'b0);

    // Masking of off channels
    curReq = "R5";
    chanOn = 16'h00F0; openLoadRaw = 16'h0F0F;
    idle(2);
    openLoadRaw = 16'hFF0F; idle(2);
    latchNow();
    openLoadRaw = 16'h0000; chanOn = 16'h0000;
    shiftN(192, 1'b0);

    // Thermal and error timing
    curReq = "R6";
    thermalFlag = 1'b1; dcValues = {16{6'b101100}};
    idle(2); latchNow(); thermalFlag = 1'b0; idle(2);
    shiftN(180, 1'b0);

    // Simultaneous latch and shift
    curReq = "R7";
    thermalFlag = 1'b1; chanOn = 16'hFFFF; openLoadRaw = 16'h8001;
    latchStb = 1'b1; shiftEn = 1'b1;
    @(negedge clk);
    latchStb = 1'b0; shiftEn = 1'b0;
    thermalFlag = 1'b0; openLoadRaw = '0;
    shiftN(60, 1'b0);
    // Reload in mid-stream
    curReq = "R2"; latchNow();
    curReq = "R4"; shiftN(192, 1'b1);
    curReq = "R8"; idle(5);

    // Reset again mid-stream
    curReq = "R1";
    thermalFlag = 1'b1; latchNow(); shiftN(3, 1'b0);
    rstN = 1'b0; thermalFlag = 1'b0; idle(3);
    rstN = 1'b1; idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule